// File: doc/BRIEF.md
# Program Memory Bank and Fetch Control

This block keeps the program counter of a small 8-bit controller and decides where each instruction fetch is served. The 4 KB program space is split into a lower and an upper 2 KB bank. Address bit 11 names the bank and the low 11 bits address within a bank. The design holds the counter and produces the fetch address from it. It also raises a flag that routes the fetch either to the on-chip 1 KB program store or to external memory.

Control transfers come from a decoder outside the block. Each one arrives as a transfer kind, an 11-bit target, and a stored bank flag that a separate set-bank instruction has written. An interrupt acknowledge loads a fixed vector. From that moment, and until the return-with-restore strobe, the bank flag has no effect on jumps and calls. Code running in an interrupt handler therefore always branches within the lower bank.

A two-state machine tracks whether a handler is running. In state `MODE_MAIN`, transition `ENTER` is taken on an accepted interrupt acknowledge and leads to `MODE_ISR`. In `MODE_ISR`, transition `LEAVE` is taken on the return-with-restore strobe and leads back to `MODE_MAIN`. Every other input combination keeps the current state.

Top module: `prog_fetch_ctrl`

## Requirements
- R1: A synchronous reset sets the fetch address to 0x000 and the machine to `MODE_MAIN` (isr_active low).
- R2: In `MODE_MAIN`, int_ack loads the vector on the same edge that enters `MODE_ISR`. The vector is 0x003 when int_src is 0 and 0x007 when int_src is 1.
- R3: In `MODE_MAIN`, a JUMP (kind 2'b01) or CALL (kind 2'b10) with step high loads bank_flag into bit 11 and xfer_target into bits 10:0.
- R4: In `MODE_ISR`, a JUMP or CALL loads bit 11 as 0 and bits 10:0 from xfer_target, whatever bank_flag holds.
- R5: The retr strobe loads ret_addr and returns the machine to `MODE_MAIN`. Later jumps and calls apply bank_flag again.
- R6: A sequential step (kind 2'b00) adds one to bits 10:0 only. It wraps inside the bank and leaves bit 11 unchanged.
- R7: With ext_access low, fetch_ext is 0 for addresses 0x000 to 0x3FF and 1 for addresses from 0x400 upward. With ext_access high, fetch_ext is always 1.
- R8: With step, int_ack and retr all low, the fetch address holds its value.
- R9: In `MODE_ISR`, int_ack is ignored. The address follows the other inputs and the machine stays in `MODE_ISR`.
- R10: An accepted int_ack takes precedence over retr and step in the same cycle. retr takes precedence over step.
- R11: A plain return (kind 2'b11) with step high loads all 12 bits of ret_addr and does not change the machine state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advances the counter by the transfer described by xfer_kind |
| xfer_kind | input | 2 | 00 sequential, 01 jump, 10 call, 11 plain return |
| xfer_target | input | 11 | In-bank target of a jump or call |
| bank_flag | input | 1 | Stored bank-select flag |
| ret_addr | input | 12 | Return address from the stack |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| int_src | input | 1 | Vector choice: 0 gives 0x003, 1 gives 0x007 |
| retr | input | 1 | Return-with-restore strobe |
| ext_access | input | 1 | Forces every fetch to external memory when high |
| fetch_addr | output | 12 | Current fetch address |
| fetch_ext | output | 1 | 1 means the fetch goes to external memory |
| isr_active | output | 1 | High while in `MODE_ISR` |

## Verification
The assertions take for granted that the decoder drives xfer_kind and xfer_target stable around the clock edge, and that the strobes are single-cycle pulses. They place no other demand on ordering. In particular, retr may arrive outside a handler and int_ack may arrive inside one. The properties state the precedence among simultaneous strobes, so they hold for every combination.

The stimulus changes every input only on the falling clock edge. It deliberately pairs the strobes with steps in the same cycle to exercise that precedence.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        XFER_SEQ  = 2'b00,
        XFER_JUMP = 2'b01,
        XFER_CALL = 2'b10,
        XFER_RET  = 2'b11
    } xfer_e;

    typedef enum logic {
        MODE_MAIN = 1'b0,
        MODE_ISR  = 1'b1
    } mode_e;

endpackage

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
    import pfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  int_ack,
    input  logic  retr,
    output mode_e mode,
    output logic  accept_int
);

    mode_e mode_q;
    mode_e mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_MAIN;
        end else begin
            mode_q <= mode_d;
        end
    end

    // transitions ENTER and LEAVE
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_MAIN: if (int_ack) mode_d = MODE_ISR;
            MODE_ISR:  if (retr)    mode_d = MODE_MAIN;
            default:   mode_d = MODE_MAIN;
        endcase
    end

    // outputs
    always_comb begin
        mode       = mode_q;
        accept_int = int_ack && (mode_q == MODE_MAIN);
    end

    AST_LEAVE_ON_RETR: assert property (@(posedge clk) disable iff (rst)
        (retr && !accept_int) |=> (mode == MODE_MAIN)); // R5

    AST_NO_NESTED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_ISR) && int_ack && !retr) |=> (mode == MODE_ISR)); // R9

endmodule

// File: rtl/pfc_next_addr.sv
module pfc_next_addr
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 11,
    parameter int VEC_A  = 3,
    parameter int VEC_B  = 7
) (
    input  logic              step,
    input  logic [1:0]        xfer_kind,
    input  logic [BANK_W-1:0] xfer_target,
    input  logic              bank_flag,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              accept_int,
    input  logic              int_src,
    input  logic              retr,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_next
);

    localparam int HI_W = ADDR_W - BANK_W;

    logic [BANK_W-1:0] low_inc;
    logic [HI_W-1:0]   bank_bits;
    xfer_e             kind;

    always_comb begin
        kind      = xfer_e'(xfer_kind);
        low_inc   = pc[BANK_W-1:0] + 1'b1;
        bank_bits = (mode == MODE_ISR) ? '0 : HI_W'(bank_flag);
        pc_next   = pc;
        if (accept_int) begin
            pc_next = int_src ? ADDR_W'(VEC_B) : ADDR_W'(VEC_A);
        end else if (retr) begin
            pc_next = ret_addr;
        end else if (step) begin
            unique case (kind)
                XFER_SEQ:  pc_next = {pc[ADDR_W-1:BANK_W], low_inc};
                XFER_JUMP,
                XFER_CALL: pc_next = {bank_bits, xfer_target};
                XFER_RET:  pc_next = ret_addr;
                default:   pc_next = pc;
            endcase
        end
    end

endmodule

// File: rtl/pfc_src_sel.sv
module pfc_src_sel #(
    parameter int ADDR_W    = 12,
    parameter int INT_MEM_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_access,
    output logic              fetch_ext
);

    logic beyond_int;

    generate
        if (INT_MEM_W < ADDR_W) begin : g_partial
            assign beyond_int = |addr[ADDR_W-1:INT_MEM_W];
        end else begin : g_full
            assign beyond_int = 1'b0;
        end
    endgenerate

    assign fetch_ext = ext_access | beyond_int;

endmodule

// File: rtl/prog_fetch_ctrl.sv
module prog_fetch_ctrl
    import pfc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK_W    = 11,
    parameter int INT_MEM_W = 10,
    parameter int VEC_A     = 3,
    parameter int VEC_B     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [1:0]        xfer_kind,
    input  logic [BANK_W-1:0] xfer_target,
    input  logic              bank_flag,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              int_ack,
    input  logic              int_src,
    input  logic              retr,
    input  logic              ext_access,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ext,
    output logic              isr_active
);

    localparam logic [ADDR_W-1:0] INT_TOP = ADDR_W'((1 << INT_MEM_W) - 1);

    mode_e             mode;
    logic              accept_int;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    pfc_mode_fsm i_mode (
        .clk        (clk),
        .rst        (rst),
        .int_ack    (int_ack),
        .retr       (retr),
        .mode       (mode),
        .accept_int (accept_int)
    );

    pfc_next_addr #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .VEC_A  (VEC_A),
        .VEC_B  (VEC_B)
    ) i_next (
        .step        (step),
        .xfer_kind   (xfer_kind),
        .xfer_target (xfer_target),
        .bank_flag   (bank_flag),
        .ret_addr    (ret_addr),
        .accept_int  (accept_int),
        .int_src     (int_src),
        .retr        (retr),
        .mode        (mode),
        .pc          (pc_q),
        .pc_next     (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    pfc_src_sel #(
        .ADDR_W    (ADDR_W),
        .INT_MEM_W (INT_MEM_W)
    ) i_src (
        .addr       (pc_q),
        .ext_access (ext_access),
        .fetch_ext  (fetch_ext)
    );

    assign fetch_addr = pc_q;
    assign isr_active = (mode == MODE_ISR);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !isr_active)); // R1

    AST_VECTOR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !isr_active) |=> (isr_active &&
            (fetch_addr == ADDR_W'(VEC_A) || fetch_addr == ADDR_W'(VEC_B)))); // R2

    AST_MAIN_BANK_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!isr_active && !int_ack && !retr && step &&
         (xfer_kind == 2'b01 || xfer_kind == 2'b10))
        |=> (fetch_addr[ADDR_W-1] == $past(bank_flag))); // R3

    AST_ISR_LOW_BANK: assert property (@(posedge clk) disable iff (rst)
        (isr_active && !retr && step &&
         (xfer_kind == 2'b01 || xfer_kind == 2'b10))
        |=> (fetch_addr[ADDR_W-1] == 1'b0)); // R4

    AST_SEQ_KEEPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (!(int_ack && !isr_active) && !retr && step && xfer_kind == 2'b00)
        |=> (fetch_addr[ADDR_W-1] == $past(fetch_addr[ADDR_W-1]))); // R6

    AST_EXT_FORCED: assert property (@(posedge clk) disable iff (rst)
        ext_access |-> fetch_ext); // R7

    AST_EXT_LOW_IS_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        (!ext_access && fetch_addr <= INT_TOP) |-> !fetch_ext); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !int_ack && !retr) |=> $stable(fetch_addr)); // R8

    AST_RETR_OVER_STEP: assert property (@(posedge clk) disable iff (rst)
        (retr && !(int_ack && !isr_active)) |=> (fetch_addr == $past(ret_addr))); // R10

endmodule

// File: tb/test_prog_fetch_ctrl.sv
module test_prog_fetch_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [1:0]  xfer_kind;
    logic [10:0] xfer_target;
    logic        bank_flag;
    logic [11:0] ret_addr;
    logic        int_ack;
    logic        int_src;
    logic        retr;
    logic        ext_access;
    logic [11:0] fetch_addr;
    logic        fetch_ext;
    logic        isr_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    prog_fetch_ctrl i_prog_fetch_ctrl (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .xfer_kind   (xfer_kind),
        .xfer_target (xfer_target),
        .bank_flag   (bank_flag),
        .ret_addr    (ret_addr),
        .int_ack     (int_ack),
        .int_src     (int_src),
        .retr        (retr),
        .ext_access  (ext_access),
        .fetch_addr  (fetch_addr),
        .fetch_ext   (fetch_ext),
        .isr_active  (isr_active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        step = 0; xfer_kind = 2'b00; xfer_target = '0; bank_flag = 0;
        ret_addr = '0; int_ack = 0; int_src = 0; retr = 0;
    endtask

    // drive on the falling edge, let one rising edge pass, sample 1 ns later
    task automatic cycle(input logic s, input logic [1:0] k, input logic [10:0] t,
                         input logic bf, input logic [11:0] ra, input logic ia,
                         input logic is, input logic rr);
        @(negedge clk);
        step = s; xfer_kind = k; xfer_target = t; bank_flag = bf;
        ret_addr = ra; int_ack = ia; int_src = is; retr = rr;
        @(posedge clk);
        #1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        ext_access = 0;
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 addr", fetch_addr, 12'h000);
        check("R1 isr", isr_active, 0);
        check("R7 ext after reset", fetch_ext, 0);
    endtask

    task automatic t_main_call_upper();
        cycle(1, 2'b10, 11'h123, 1, '0, 0, 0, 0);
        check("R3 call upper", fetch_addr, 12'h923);
        check("R7 upper bank ext", fetch_ext, 1);
        cycle(1, 2'b00, '0, 0, '0, 0, 0, 0);
        check("R6 seq", fetch_addr, 12'h924);
    endtask

    task automatic t_seq_wrap();
        cycle(1, 2'b01, 11'h7FF, 1, '0, 0, 0, 0);
        check("R3 jump", fetch_addr, 12'hFFF);
        cycle(1, 2'b00, '0, 0, '0, 0, 0, 0);
        check("R6 wrap in bank", fetch_addr, 12'h800);
    endtask

    task automatic t_hold();
        cycle(0, 2'b01, 11'h055, 1, 12'h111, 0, 0, 0);
        check("R8 hold", fetch_addr, 12'h800);
    endtask

    task automatic t_isr_call();
        cycle(1, 2'b01, 11'h010, 1, '0, 1, 0, 0);
        check("R10 int over step", fetch_addr, 12'h003);
        check("R2 isr set", isr_active, 1);
        check("R7 vector internal", fetch_ext, 0);
        cycle(1, 2'b10, 11'h123, 1, '0, 0, 0, 0);
        check("R4 call stays low bank", fetch_addr, 12'h123);
        cycle(1, 2'b01, 11'h456, 1, '0, 0, 0, 0);
        check("R4 jump stays low bank", fetch_addr, 12'h456);
        cycle(1, 2'b00, '0, 0, '0, 1, 1, 0);
        check("R9 nested ack ignored addr", fetch_addr, 12'h457);
        check("R9 still isr", isr_active, 1);
        cycle(1, 2'b11, '0, 0, 12'hABC, 0, 0, 0);
        check("R11 plain return", fetch_addr, 12'hABC);
        check("R11 mode kept", isr_active, 1);
        cycle(1, 2'b01, 11'h020, 1, 12'h924, 0, 0, 1);
        check("R10 retr over step", fetch_addr, 12'h924);
        check("R5 isr cleared", isr_active, 0);
        cycle(1, 2'b10, 11'h055, 1, '0, 0, 0, 0);
        check("R5 bank flag honoured again", fetch_addr, 12'h855);
    endtask

    task automatic t_vector_b();
        cycle(0, 2'b00, '0, 0, '0, 1, 1, 0);
        check("R2 vector 7", fetch_addr, 12'h007);
        check("R2 isr", isr_active, 1);
        @(negedge clk);
        ext_access = 1;
        #1;
        check("R7 pin high forces ext", fetch_ext, 1);
        @(negedge clk);
        ext_access = 0;
        cycle(0, 2'b00, '0, 0, 12'h3FF, 0, 0, 1);
        check("R5 retr loads", fetch_addr, 12'h3FF);
        check("R7 last internal", fetch_ext, 0);
        cycle(1, 2'b00, '0, 0, '0, 0, 0, 0);
        check("R7 first external", fetch_ext, 1);
        check("R6 carry within bank", fetch_addr, 12'h400);
        cycle(1, 2'b01, 11'h7FE, 0, '0, 0, 0, 0);
        check("R3 flag low", fetch_addr, 12'h7FE);
    endtask

    initial begin
        rst = 1;
        t_reset();
        t_main_call_upper();
        t_seq_wrap();
        t_hold();
        t_isr_call();
        t_vector_b();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule